// File: doc/BRIEF.md
# Cascaded Load Clock Divider

This block derives two slower clocks from a fast pixel clock in a video clock generator. The first stage divides the pixel clock by one of six fixed ratios to form the load clock, which feeds shift and load logic downstream. The second stage counts periods of the load clock and divides it again by any integer from 1 to 512 to give a secondary clock. A suppress control stops both outputs. When suppress is released, both dividers begin again from the start of a period.

Both stages run in the pixel clock domain. The second stage advances on a one-cycle strobe that marks each rising edge of the load clock, so it never uses a derived clock. Both outputs come straight from flops and are aligned to each other. A new ratio is taken up by a stage only when that stage finishes its current period, so a period in progress is never cut short or stretched.

Top module: `lclk_div_chain`

## Requirements
- R1: The `ratio_sel` code sets the load clock period in pixel clocks. Code 0 gives 3, 1 gives 4, 2 gives 5, 3 gives 6, 4 gives 8 and 5 gives 10. Codes 6 and 7 give 4.
- R2: In each load clock period of N pixel clocks, `load_clk` is high for floor(N/2) cycles and low for the rest.
- R3: When `sec_div` holds a value V from 1 to 511, the `sec_clk` period is (V+1) load periods. `sec_clk` rises together with `load_clk` and stays high for floor((V+1)/2) load periods.
- R4: When `sec_div` is 0, `sec_clk` is an exact copy of `load_clk`.
- R5: While `suppress` is 1, both `load_clk` and `sec_clk` are low from the first clock edge that samples it.
- R6: At the first clock edge after `suppress` returns to 0, `load_clk` and `sec_clk` both go high, and a full first period of each follows.
- R7: A change of `ratio_sel` does not alter the load period in progress. It takes effect from the next load period.
- R8: A change of `sec_div` does not alter the `sec_clk` period in progress. It takes effect from the next `sec_clk` period.
- R9: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ratio_sel | input | 3 | First-stage ratio code |
| suppress | input | 1 | Holds both outputs low and restarts the dividers when it is released |
| sec_div | input | 9 | Second-stage divisor minus one |
| load_clk | output | 1 | Load clock, pixel clock divided by the selected ratio |
| sec_clk | output | 1 | Secondary clock, load clock divided by sec_div+1 |

## Verification
Two ratio updates can land on the same edge. The terminal count of the load divider, where a new first-stage ratio is taken up, can also be the terminal count of the secondary divider, where a new divisor is taken up. The bench provokes this by changing both `ratio_sel` and `sec_div` just after a `sec_clk` rising edge. It then checks two periods. The `sec_clk` period already in progress must keep the old divisor but pick up the new load ratio after its first load period. The next `sec_clk` period must equal the new divisor times the new load ratio.

// File: rtl/lclk_pkg.sv
package lclk_pkg;
  localparam int SEL_W  = 3;
  localparam int CNT1_W = 4;
  localparam int SEC_W  = 9;

  function automatic logic [CNT1_W-1:0] ratio_of_code(input logic [SEL_W-1:0] code);
    logic [CNT1_W-1:0] r;
    case (code)
      3'd0:    r = 4'd3;
      3'd1:    r = 4'd4;
      3'd2:    r = 4'd5;
      3'd3:    r = 4'd6;
      3'd4:    r = 4'd8;
      3'd5:    r = 4'd10;
      default: r = 4'd4;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lclk_stage1.sv
module lclk_stage1
  import lclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             hold,
  output logic             load_o,
  output logic             load_nxt_o,
  output logic             wrap_o,
  output logic             restart_o
);
  logic [CNT1_W-1:0] cnt_q, cnt_d, ratio_q, ratio_d;
  logic              run_q, run_d, load_q, load_d;
  logic              wrap, restart;

  always_comb begin
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    run_d   = run_q;
    wrap    = 1'b0;
    restart = 1'b0;
    if (hold) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (!run_q) begin
      run_d   = 1'b1;
      cnt_d   = '0;
      ratio_d = ratio_of_code(sel);
      wrap    = 1'b1;
      restart = 1'b1;
    end else if (cnt_q == ratio_q - 1'b1) begin
      cnt_d   = '0;
      ratio_d = ratio_of_code(sel);
      wrap    = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    load_d = !hold && (cnt_d < (ratio_d >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= 4'd4;
      run_q   <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      run_q   <= run_d;
      load_q  <= load_d;
    end
  end

  assign load_o     = load_q;
  assign load_nxt_o = load_d;
  assign wrap_o     = wrap;
  assign restart_o  = restart;

  p_low_when_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !load_q);
  p_ratio_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (ratio_q == 4'd3 || ratio_q == 4'd4 || ratio_q == 4'd5 ||
               ratio_q == 4'd6 || ratio_q == 4'd8 || ratio_q == 4'd10));
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < ratio_q));
  p_ratio_at_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !hold && cnt_q != ratio_q - 1'b1) |=> $stable(ratio_q));
endmodule

// File: rtl/lclk_stage2.sv
module lclk_stage2
  import lclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] val,
  input  logic             hold,
  input  logic             en,
  input  logic             restart,
  input  logic             load_nxt,
  output logic             out_o
);
  logic [SEC_W-1:0] c2_q, c2_d, m2_q, m2_d;
  logic [SEC_W:0]   hi_len;
  logic             out_q, out_d;

  always_comb begin
    c2_d = c2_q;
    m2_d = m2_q;
    if (hold) begin
      c2_d = '0;
    end else if (en) begin
      if (restart || c2_q == m2_q) begin
        c2_d = '0;
        m2_d = val;
      end else begin
        c2_d = c2_q + 1'b1;
      end
    end
    hi_len = ({1'b0, m2_d} + 1'b1) >> 1;
    if (hold)
      out_d = 1'b0;
    else if (m2_d == '0)
      out_d = load_nxt;
    else
      out_d = ({1'b0, c2_d} < hi_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_q  <= '0;
      m2_q  <= '0;
      out_q <= 1'b0;
    end else begin
      c2_q  <= c2_d;
      m2_q  <= m2_d;
      out_q <= out_d;
    end
  end

  assign out_o = out_q;

  p_sec_low_when_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !out_q);
  p_cnt2_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c2_q <= m2_q);
  p_div_at_tc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && (restart || c2_q == m2_q)) |=> $stable(m2_q));
  p_count_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !hold) |=> $stable(c2_q));
endmodule

// File: rtl/lclk_div_chain.sv
module lclk_div_chain
  import lclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             suppress,
  input  logic [SEC_W-1:0] sec_div,
  output logic             load_clk,
  output logic             sec_clk
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       load_nxt, wrap, restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lclk_stage1 u_stage1 (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sel        (ratio_sel),
    .hold       (suppress),
    .load_o     (load_clk),
    .load_nxt_o (load_nxt),
    .wrap_o     (wrap),
    .restart_o  (restart)
  );

  lclk_stage2 u_stage2 (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .val      (sec_div),
    .hold     (suppress),
    .en       (wrap),
    .restart  (restart),
    .load_nxt (load_nxt),
    .out_o    (sec_clk)
  );

  p_rise_together_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sec_clk) |-> $rose(load_clk));
  p_reset_low_r9: assert property (@(posedge clk)
    !rst_int_n |=> (!load_clk && !sec_clk));
endmodule

// File: tb/lclk_div_chain_bench.sv
module lclk_div_chain_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] ratio_sel;
  logic       suppress;
  logic [8:0] sec_div;
  logic       load_clk, sec_clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  lclk_div_chain u_lclk_div_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .suppress  (suppress),
    .sec_div   (sec_div),
    .load_clk  (load_clk),
    .sec_clk   (sec_clk)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int exp_ratio(input int code);
    case (code)
      0: return 3;
      1: return 4;
      2: return 5;
      3: return 6;
      4: return 8;
      5: return 10;
      default: return 4;
    endcase
  endfunction

  function automatic logic pick(input bit sec);
    return sec ? sec_clk : load_clk;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise(input bit sec);
    logic prev, cur;
    prev = pick(sec);
    forever begin
      @(negedge clk);
      cur = pick(sec);
      if (!prev && cur) break;
      prev = cur;
    end
  endtask

  // Called on a rising-edge sample; returns on the next rising-edge sample.
  task automatic meas_period(input bit sec, output int hi, output int per);
    logic prev, cur;
    hi = 1; per = 1; prev = 1'b1;
    forever begin
      @(negedge clk);
      cur = pick(sec);
      if (!prev && cur) break;
      per = per + 1;
      if (cur) hi = hi + 1;
      prev = cur;
    end
  endtask

  task automatic restart(input int code, input int val);
    @(negedge clk);
    suppress  = 1'b1;
    ratio_sel = code[2:0];
    sec_div   = val[8:0];
    repeat (3) @(negedge clk);
    suppress = 1'b0;
  endtask

  task automatic check_config(input int code, input int val);
    int hi, per, n, m;
    n = exp_ratio(code);
    m = val + 1;
    restart(code, val);
    wait_rise(1'b0);
    meas_period(1'b0, hi, per);
    chk(per == n, "R1 load period", per, n);
    chk(hi == n / 2, "R2 load high time", hi, n / 2);
    wait_rise(1'b1);
    meas_period(1'b1, hi, per);
    if (val == 0) begin
      chk(per == n, "R4 copy period", per, n);
      chk(hi == n / 2, "R4 copy high time", hi, n / 2);
    end else begin
      chk(per == m * n, "R3 sec period", per, m * n);
      chk(hi == (m / 2) * n, "R3 sec high time", hi, (m / 2) * n);
    end
  endtask

  initial begin
    int hi, per, bad;
    void'($urandom(32'd5127));
    rst_n = 1'b0; ratio_sel = 3'd0; suppress = 1'b0; sec_div = 9'd0;
    repeat (4) @(negedge clk);
    chk(!load_clk && !sec_clk, "R9 outputs low in reset", {load_clk, sec_clk}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2 / R4: every ratio code with the copy mode
    for (int c = 0; c < 8; c++) check_config(c, 0);
    // R3 boundary: largest divisor, smallest ratio
    check_config(0, 511);
    check_config(5, 1);
    // random mix
    for (int t = 0; t < 12; t++) check_config($urandom % 8, $urandom % 40);

    // R5: suppress mid-run holds both low
    restart(3, 4);
    repeat (7) @(negedge clk);
    suppress = 1'b1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (load_clk || sec_clk) bad = bad + 1;
    end
    chk(bad == 0, "R5 outputs held low", bad, 0);

    // R6: release restarts both from a fresh period
    ratio_sel = 3'd4; sec_div = 9'd3;
    @(negedge clk);
    suppress = 1'b0;
    @(negedge clk);
    chk(load_clk && sec_clk, "R6 both rise after release", {load_clk, sec_clk}, 3);
    meas_period(1'b0, hi, per);
    chk(per == 8, "R6 full first load period", per, 8);

    // R7: ratio change applies at the next load period
    restart(0, 0);
    wait_rise(1'b0);
    ratio_sel = 3'd5;
    meas_period(1'b0, hi, per);
    chk(per == 3, "R7 old ratio finishes", per, 3);
    meas_period(1'b0, hi, per);
    chk(per == 10, "R7 new ratio taken", per, 10);

    // R8: divisor change applies at the next sec period
    restart(0, 2);
    wait_rise(1'b1);
    sec_div = 9'd4;
    meas_period(1'b1, hi, per);
    chk(per == 9, "R8 old divisor finishes", per, 9);
    meas_period(1'b1, hi, per);
    chk(per == 15, "R8 new divisor taken", per, 15);

    // R7 + R8 together: both ratios change right after a sec rise
    restart(0, 2);
    wait_rise(1'b1);
    ratio_sel = 3'd4; sec_div = 9'd1;
    meas_period(1'b1, hi, per);
    chk(per == 19, "R7 R8 mixed period", per, 19);
    chk(hi == 3, "R7 R8 mixed high time", hi, 3);
    meas_period(1'b1, hi, per);
    chk(per == 16, "R8 R7 new pair period", per, 16);
    chk(hi == 8, "R8 R7 new pair high time", hi, 8);

    // R9: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!load_clk && !sec_clk, "R9 outputs low after reset", {load_clk, sec_clk}, 0);
    rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule